// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns 32-bit virtual addresses from a processor into physical addresses using 4 KB pages. The low 12 bits of the address are the byte offset and pass through unchanged. The upper 20 bits are the page number, and they are replaced by a 20-bit frame number. The physical address is the frame number followed by the offset.

A small fully associative translation cache (TLB) is searched first. On a hit the answer is produced directly. On a miss, a hardware walker reads a two-level page table through a single-beat memory read port:
- The page number splits into a 10-bit directory index (address bits 31:22) and a 10-bit inner index (bits 21:12).
- The walker first reads the directory entry. It is found at the table base frame, at byte offset 4 × directory index.
- That entry names the frame holding the inner table. The walker then reads the inner entry at byte offset 4 × inner index inside that frame.
- A valid inner entry refills the cache and the translation is returned.

Every table entry is 4 bytes wide: bits 31:12 hold a frame number and bit 0 is the valid bit. Software loads the table base and pulses a flush on a context switch. Only one request is in flight at a time.

Top module: `xlat_mmu`

## Requirements
- R1: A request that hits the cache is answered in the cycle right after the clock edge that accepts it. The answer is `rsp_valid`=1, `rsp_fault`=0 and `rsp_paddr` = {cached frame, vaddr[11:0]}.
- R2: On a miss the walker issues exactly two reads, in this order:
  - first the directory read at {base[31:12], vaddr[31:22], 2'b00};
  - then the inner read at {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R3: A successful walk answers one cycle after the edge that captures the inner read's `mem_ack`. It returns {inner_entry[31:12], vaddr[11:0]} with `rsp_fault`=0. With w wait cycles per read, the answer follows the accepting edge by 3+2w edges.
- R4: A directory entry with bit 0 = 0 ends the walk with `rsp_fault`=1 and `rsp_paddr`=0 one cycle after its acknowledge. No inner read is issued and there is no refill.
- R5: An inner entry with bit 0 = 0 ends the walk with a fault one cycle after its acknowledge. No refill is made, so repeating the same request walks again.
- R6: After a successful walk, the next request to the same page hits (R1 timing). This holds for any offset.
- R7: Refills go to the slot named by a round-robin pointer. The pointer advances by one on every refill and is not reset by invalidation. The ninth distinct refill therefore evicts the page placed eight refills earlier.
- R8: A `flush` pulse invalidates all cache entries. Later requests miss and walk.
- R9: A `base_we` pulse loads the table base from `base_wdata[31:12]` and also invalidates every cache entry.
- R10: A `flush` or `base_we` that arrives while a walk is running still lets that walk answer, but suppresses its refill.
- R11: `req_ready` is 1 only while no request is pending. `mem_req` stays high with a stable `mem_addr` until `mem_ack`.
- R12: After reset the cache is empty, `req_ready`=1, and both `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Invalid table entry met |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table entry byte address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Table entry read |
| base_we | input | 1 | Load table base, invalidate cache |
| base_wdata | input | 32 | New table base (bits 31:12 used) |
| flush | input | 1 | Invalidate all cache entries |

## Verification
The due cycle of each response depends on the path the request takes:
- a hit answers zero edges after the accepting edge, as seen at the following falling edge;
- a directory fault answers 1+w edges after it;
- an inner fault answers 2+2w edges after it;
- a full walk answers 3+2w edges after it.

The bench model predicts which path a request takes and the memory wait w, then checks `rsp_valid` and `req_ready` at every falling edge up to the due one. A response that comes early, comes late or is missing is therefore caught. Each table read address is compared with the model's expected sequence on the cycle it is acknowledged.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_DIR    = 2'd1,
      WK_INNER  = 2'd2,
      WK_REFILL = 2'd3
   } wk_state_e;
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned PFN_W   = 20,
   parameter int unsigned ENTRIES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   input  logic             inv_all,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PFN_W-1:0] wr_pfn
);
   localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   initial begin
      assert (ENTRIES >= 2 && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("xlat_tlb: ENTRIES must be a power of two >= 2");
   end

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] match;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
   end

   always_comb begin
      lk_pfn = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
   end
   assign lk_hit = |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (inv_all) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[ptr_q] <= 1'b1;
         ptr_q        <= PTR_W'(ptr_q + 1'b1);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !inv_all) begin
         tag_q[ptr_q] <= wr_tag;
         pfn_q[ptr_q] <= wr_pfn;
      end
   end

   // R8: invalidation empties every slot
   a_r8_inv_empties: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (vld_q == '0));
   // R6: refills never create two matching slots
   a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R6: a refill makes its written tag visible next cycle
   a_r6_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inv_all) |=> vld_q[$past(ptr_q)]);
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
   import xlat_pkg::*;
#(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned OFF_W = 12,
   parameter int unsigned LVL_W = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [VA_W-1:0]        start_va,
   input  logic                   tlb_hit,
   input  logic [VA_W-OFF_W-1:0]  tlb_pfn,
   input  logic [VA_W-OFF_W-1:0]  base_pfn,
   input  logic                   inv_any,
   output logic                   idle,
   output logic                   mem_req,
   output logic [VA_W-1:0]        mem_addr,
   input  logic                   mem_ack,
   input  logic [VA_W-1:0]        mem_rdata,
   output logic                   rsp_valid,
   output logic [VA_W-1:0]        rsp_paddr,
   output logic                   rsp_fault,
   output logic                   fill_we,
   output logic [VA_W-OFF_W-1:0]  fill_vpn,
   output logic [VA_W-OFF_W-1:0]  fill_pfn
);
   localparam int unsigned PFN_W = VA_W - OFF_W;
   localparam int unsigned ENT_B = OFF_W - LVL_W;

   initial begin
      assert (PFN_W == 2 * LVL_W) else $error("xlat_ctrl: page number must split in two equal levels");
      assert (ENT_B == 2) else $error("xlat_ctrl: one table level must fill one page of 4-byte entries");
   end

   wk_state_e           st_q;
   logic [VA_W-1:0]     va_q;
   logic [PFN_W-1:0]    frame_q;
   logic                stale_q;
   logic                ent_ok;
   logic [PFN_W-1:0]    ent_pfn;

   assign ent_ok  = mem_rdata[0];
   assign ent_pfn = mem_rdata[VA_W-1:OFF_W];
   assign idle    = (st_q == WK_IDLE);
   assign mem_req = (st_q == WK_DIR) || (st_q == WK_INNER);

   always_comb begin
      if (st_q == WK_DIR)
         mem_addr = {frame_q, va_q[VA_W-1 -: LVL_W], {ENT_B{1'b0}}};
      else
         mem_addr = {frame_q, va_q[OFF_W+LVL_W-1 -: LVL_W], {ENT_B{1'b0}}};
   end

   assign fill_we  = (st_q == WK_REFILL) && !stale_q && !inv_any;
   assign fill_vpn = va_q[VA_W-1:OFF_W];
   assign fill_pfn = frame_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= WK_IDLE;
         va_q      <= '0;
         frame_q   <= '0;
         stale_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (st_q != WK_IDLE && inv_any) stale_q <= 1'b1;
         case (st_q)
            WK_IDLE: if (start) begin
               va_q    <= start_va;
               stale_q <= 1'b0;
               if (tlb_hit) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_paddr <= {tlb_pfn, start_va[OFF_W-1:0]};
               end else begin
                  frame_q <= base_pfn;
                  st_q    <= WK_DIR;
               end
            end
            WK_DIR, WK_INNER: if (mem_ack) begin
               if (!ent_ok) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b1;
                  rsp_paddr <= '0;
                  st_q      <= WK_IDLE;
               end else begin
                  frame_q <= ent_pfn;
                  st_q    <= (st_q == WK_DIR) ? WK_INNER : WK_REFILL;
               end
            end
            default: begin
               rsp_valid <= 1'b1;
               rsp_fault <= 1'b0;
               rsp_paddr <= {frame_q, va_q[OFF_W-1:0]};
               st_q      <= WK_IDLE;
            end
         endcase
      end
   end

   // R11: a pending read holds its address until acknowledged
   a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R4: invalid directory entry faults at once, no inner read
   a_r4_dir_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WK_DIR && mem_ack && !ent_ok) |=> (rsp_valid && rsp_fault && !mem_req && rsp_paddr == '0));
   // R3: refill cycle is followed by a good response
   a_r3_refill_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WK_REFILL) |=> (rsp_valid && !rsp_fault));
   // R10: a walk overtaken by invalidation never refills
   a_r10_stale_nofill: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WK_INNER && inv_any) |=> !fill_we);
endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu #(
   parameter int unsigned VA_W        = 32,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned LVL_W       = 10,
   parameter int unsigned TLB_ENTRIES = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   output logic            rsp_valid,
   output logic [VA_W-1:0] rsp_paddr,
   output logic            rsp_fault,
   output logic            mem_req,
   output logic [VA_W-1:0] mem_addr,
   input  logic            mem_ack,
   input  logic [VA_W-1:0] mem_rdata,
   input  logic            base_we,
   input  logic [VA_W-1:0] base_wdata,
   input  logic            flush
);
   localparam int unsigned PFN_W = VA_W - OFF_W;

   logic [PFN_W-1:0] base_q, base_nxt;
   logic             inv_any, start, idle;
   logic             hit_raw, hit_eff;
   logic [PFN_W-1:0] hit_pfn;
   logic             fill_we;
   logic [PFN_W-1:0] fill_vpn, fill_pfn;

   assign inv_any  = flush | base_we;
   assign base_nxt = base_we ? base_wdata[VA_W-1:OFF_W] : base_q;
   assign req_ready = idle;
   assign start     = req_valid & idle;
   assign hit_eff   = hit_raw & ~inv_any;

   always_ff @(posedge clk) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= base_nxt;
   end

   xlat_tlb #(.TAG_W(PFN_W), .PFN_W(PFN_W), .ENTRIES(TLB_ENTRIES)) u_tlb (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_tag  (req_vaddr[VA_W-1:OFF_W]),
      .lk_hit  (hit_raw),
      .lk_pfn  (hit_pfn),
      .inv_all (inv_any),
      .wr_en   (fill_we),
      .wr_tag  (fill_vpn),
      .wr_pfn  (fill_pfn)
   );

   xlat_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .LVL_W(LVL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_va  (req_vaddr),
      .tlb_hit   (hit_eff),
      .tlb_pfn   (hit_pfn),
      .base_pfn  (base_nxt),
      .inv_any   (inv_any),
      .idle      (idle),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .rsp_valid (rsp_valid),
      .rsp_paddr (rsp_paddr),
      .rsp_fault (rsp_fault),
      .fill_we   (fill_we),
      .fill_vpn  (fill_vpn),
      .fill_pfn  (fill_pfn)
   );

   // R11: no new request is taken while a table read is pending
   a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);
   // R1: a hit answers on the next cycle without touching memory
   a_r1_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
      (start && hit_eff) |=> (rsp_valid && !rsp_fault && !mem_req));
endmodule

// File: tb/tb_xlat_mmu.sv
module tb_xlat_mmu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        base_we = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        flush = 1'b0;

   always #5 clk = ~clk;

   xlat_mmu dut (.*);

   int n_chk = 0, n_bad = 0, mem_wait = 0, wcnt = 0;
   logic [31:0] pmem [logic [31:0]];
   logic [31:0] exp_addr_q [$];
   // behavioural reference state
   bit          m_v [8];
   logic [19:0] m_tag [8];
   logic [19:0] m_pfn [8];
   int          m_ptr = 0;
   logic [31:0] m_base = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   // memory responder: acks after mem_wait idle cycles, checks address order (R2)
   always @(negedge clk) begin
      if (mem_req) begin
         if (wcnt == mem_wait) begin
            logic [31:0] ea;
            ea = (exp_addr_q.size() > 0) ? exp_addr_q.pop_front() : 32'hDEAD_BEEF;
            chk(mem_addr == ea, "R2 read address", mem_addr, ea);
            mem_ack   <= 1'b1;
            mem_rdata <= rd(mem_addr);
            wcnt = 0;
         end else begin
            mem_ack <= 1'b0;
            wcnt++;
         end
      end else begin
         mem_ack <= 1'b0;
         wcnt = 0;
      end
   end

   task automatic m_clear();
      for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
   endtask

   task automatic map_page(input logic [31:0] base, input logic [31:0] va, input logic [19:0] pfn);
      logic [19:0] inner;
      inner = base[31:12] + 20'h1 + 20'(va[31:22]);
      pmem[{base[31:12], va[31:22], 2'b00}] = {inner, 11'h0, 1'b1};
      pmem[{inner, va[21:12], 2'b00}]       = {pfn, 11'h0, 1'b1};
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      m_clear();
   endtask

   task automatic set_base(input logic [31:0] b);
      @(negedge clk); base_we = 1'b1; base_wdata = b;
      @(negedge clk); base_we = 1'b0;
      m_base = b;
      m_clear();
   endtask

   // inv_kind: 0 none, 1 flush, 2 base write (same base), pulsed after edge inv_k
   task automatic issue(input logic [31:0] va, input int inv_k, input int inv_kind, input string tag);
      int lat; bit hit, flt, refill; logic [31:0] pa, d, e, da, ia;
      hit = 0; flt = 0; refill = 0; pa = '0;
      for (int i = 0; i < 8; i++)
         if (m_v[i] && m_tag[i] == va[31:12]) begin hit = 1; pa = {m_pfn[i], va[11:0]}; end
      if (hit) lat = 0;
      else begin
         da = {m_base[31:12], va[31:22], 2'b00};
         exp_addr_q.push_back(da);
         d = rd(da);
         if (!d[0]) begin lat = 1 + mem_wait; flt = 1; end
         else begin
            ia = {d[31:12], va[21:12], 2'b00};
            exp_addr_q.push_back(ia);
            e = rd(ia);
            if (!e[0]) begin lat = 2 + 2 * mem_wait; flt = 1; end
            else begin lat = 3 + 2 * mem_wait; pa = {e[31:12], va[11:0]}; refill = (inv_kind == 0); end
         end
      end
      if (inv_kind != 0) m_clear();
      if (refill) begin
         m_v[m_ptr] = 1'b1; m_tag[m_ptr] = va[31:12]; m_pfn[m_ptr] = pa[31:12];
         m_ptr = (m_ptr + 1) % 8;
      end
      chk(req_ready == 1'b1, "R11 ready before request", 32'(req_ready), 32'h1);
      req_valid = 1'b1; req_vaddr = va;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k <= lat; k++) begin
         if (k > 0) begin @(posedge clk); @(negedge clk); end
         flush   = (inv_kind == 1 && k == inv_k);
         base_we = (inv_kind == 2 && k == inv_k);
         base_wdata = m_base;
         chk(rsp_valid == (k == lat), {tag, " response timing"}, 32'(rsp_valid), 32'(k == lat));
         chk(req_ready == (k == lat), "R11 ready while busy", 32'(req_ready), 32'(k == lat));
         if (k == lat) begin
            chk(rsp_fault == flt, {tag, " fault flag"}, 32'(rsp_fault), 32'(flt));
            chk(rsp_paddr == pa, {tag, " physical address"}, rsp_paddr, pa);
         end
      end
      flush = 1'b0; base_we = 1'b0;
   endtask

   function automatic logic [31:0] vpg(input int i);
      return {10'(i), 10'(i * 3 + 1), 12'h0};
   endfunction

   bit done = 0;
   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R12 reset outputs",
          {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && mem_req == 1'b0, "R12 idle after reset", {30'b0, req_ready, mem_req}, 32'h2);

      set_base(32'h0010_0000);                       // R9 base load
      for (int i = 0; i < 10; i++) map_page(32'h0010_0000, vpg(i), 20'hA0000 + 20'(i));

      issue(vpg(0) | 32'h123, -1, 0, "R3");          // R2 R3 cold miss
      issue(vpg(0) | 32'hFFC, -1, 0, "R1");          // R1 R6 hit, other offset
      issue(vpg(0), -1, 0, "R6");
      mem_wait = 2;
      issue(vpg(1) | 32'h004, -1, 0, "R3");          // R3 with wait states
      issue(vpg(1) | 32'h008, -1, 0, "R6");
      mem_wait = 0;

      issue({10'd500, 10'd1, 12'h0AB}, -1, 0, "R4"); // R4 invalid directory
      issue({10'd0, 10'd700, 12'h010}, -1, 0, "R5"); // R5 invalid inner
      issue({10'd0, 10'd700, 12'h010}, -1, 0, "R5"); // R5 no refill: walks again

      do_flush();                                     // R8
      issue(vpg(0), -1, 0, "R8");

      do_flush();                                     // R7 round robin eviction
      for (int i = 0; i < 9; i++) issue(vpg(i) | 32'(i), -1, 0, "R7");
      issue(vpg(1), -1, 0, "R7");
      issue(vpg(0), -1, 0, "R7");

      do_flush();                                     // R10 invalidation during walk
      issue(vpg(2), 1, 1, "R10");
      issue(vpg(2), -1, 0, "R10");
      issue(vpg(4), 1, 2, "R10");
      issue(vpg(4), -1, 0, "R10");

      map_page(32'h0080_0000, vpg(3), 20'hB0003);    // R9 new table
      issue(vpg(3), -1, 0, "R9");
      set_base(32'h0080_0000);
      issue(vpg(3) | 32'h777, -1, 0, "R9");
      issue(vpg(3) | 32'h001, -1, 0, "R9");

      repeat (2) @(negedge clk);
      chk(exp_addr_q.size() == 0, "R2 all reads issued", 32'(exp_addr_q.size()), 32'h0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule